// File: doc/BRIEF.md
# Dual-Accumulator Execute Unit

This block is the data half of a small sequencer that runs 16-bit instruction words. It keeps two 32-bit accumulators and executes the arithmetic, logical, move and shift operations that target them: forms with a short immediate packed into the instruction word, forms that take a 16-bit immediate from a second parameter word, and forms that combine the two accumulators. It also moves 32-bit values between an accumulator and an internal register bus, with the 16-bit bus address taken from the parameter word.

The sequencer presents an instruction word and its parameter word together with `instr_valid`. The unit takes the instruction on any rising edge where `instr_ready` is high. Register-only operations finish in that edge. Loads and stores start a valid/ready transfer on the register bus and hold the unit until it completes. Completion is shown by a one-cycle `done` pulse. A word the unit does not recognise gives a one-cycle `illegal` pulse instead. After every result written to an accumulator, the zero and less-or-equal flags are refreshed for the branch logic. Program-counter sequencing and branch decoding are outside this block.

Top module: `dual_acc_exec`

## Requirements
- R1: After reset both accumulators are 0, `flag_z` and `flag_le` are 1, and `done`, `illegal` and `bus_valid` are 0.
- R2: A word with bits 15..12 = 1010 is a short-immediate operation. The immediate is bits 7..1, zero-extended. Bit 0 selects the accumulator (0 picks acc0, 1 picks acc1). Code 0000 in bits 11..8 adds the immediate, 0001 subtracts it (modulo 2^32), and 0010 replaces the whole accumulator with it.
- R3: Among short-immediate operations, code 1000 ANDs the immediate into the accumulator. Code 1110 shifts the accumulator left and code 1111 shifts it right logically, by the immediate; an amount of 32 or more gives 0. Any other code in bits 11..8 is illegal.
- R4: A word 0xE00 followed by bits 3..1 = ooo and bit 0 = A uses the parameter word, zero-extended, as the operand. ooo = 001 subtracts, 010 moves, 100 ANDs and 101 ORs. Any other ooo is illegal.
- R5: Words 0xE04 followed by 00BA (A += B), 0xE05 followed by 00BA (A &= B) and 0xE05 followed by 01BA (A |= B) combine the two accumulators. B is bit 1 and A is bit 0, and A may equal B.
- R6: Each time a result is written to an accumulator, `flag_z` is set to (result == 0) and `flag_le` to (result as signed 32-bit <= 0).
- R7: Word 0xE0C followed by 000A loads accumulator A. It raises `bus_valid` with `bus_write` = 0 and `bus_addr` = parameter word. On the edge where `bus_ready` is seen, it writes `bus_rdata` into A, updates the flags, and pulses `done` in the following cycle.
- R8: Word 0xE0C followed by 001A stores accumulator A. It drives `bus_write` = 1, `bus_wdata` = A and `bus_addr` = parameter word, and leaves both accumulators and both flags unchanged.
- R9: While a transfer waits for `bus_ready`, the address, write data and direction stay stable and `instr_ready` is low. Instruction words offered in that time are ignored.
- R10: Word 0xE190 is a no-op: it pulses `done` and changes no accumulator and no flag.
- R11: Any other word gives a single `illegal` pulse in the cycle after acceptance, no `done`, and no change to accumulators or flags.
- R12: A register-only operation pulses `done` in the cycle after the edge that accepts it, and the new accumulator value is visible in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction and parameter words are presented |
| instr_ready | output | 1 | Unit can accept an instruction this cycle |
| instr_word | input | 16 | Instruction word |
| param_word | input | 16 | Parameter word (16-bit immediate or bus address) |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle unrecognised-word pulse |
| acc0 | output | 32 | Accumulator 0 |
| acc1 | output | 32 | Accumulator 1 |
| flag_z | output | 1 | Last written result was zero |
| flag_le | output | 1 | Last written result was signed less-or-equal to zero |
| bus_valid | output | 1 | Register-bus transfer request |
| bus_write | output | 1 | 1 for store, 0 for load |
| bus_addr | output | 16 | Register-bus address |
| bus_wdata | output | 32 | Store data |
| bus_ready | input | 1 | Register bus accepts or returns data |
| bus_rdata | input | 32 | Load data |

## Verification
On every cycle the assertions check the bus protocol: address, data and direction hold while a request waits, `instr_ready` drops during a transfer, and `done` follows each handshake. They also check that stores, no-ops and illegal pulses leave the accumulators and flags untouched, and that a zero flag always implies less-or-equal. Only the bench's scenarios can show that each operation computes the right value. To do that, the bench sweeps all 65,536 instruction words against a model of the requirements, including the illegal holes in each encoding group and shifts of 32 or more. Directed cases cover a stalled transfer with instructions offered during the stall, and the signed flag corner at 0x80000000.

// File: rtl/dual_acc_exec.sv
module dual_acc_exec #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [IW-1:0] instr_word,
  input  logic [IW-1:0] param_word,
  output logic          done,
  output logic          illegal,
  output logic [DW-1:0] acc0,
  output logic [DW-1:0] acc1,
  output logic          flag_z,
  output logic          flag_le,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [IW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata
);

  typedef enum logic [2:0] {K_ALU, K_NOP, K_LOAD, K_STORE, K_BAD} kind_t;

  logic [DW-1:0] acc_q [2];
  logic          ld_sel;
  kind_t         kind;
  logic [DW-1:0] res;

  wire           sel_a = instr_word[0];
  wire           sel_b = instr_word[1];
  wire [DW-1:0]  opa   = acc_q[sel_a];
  wire [DW-1:0]  opb   = acc_q[sel_b];
  wire [DW-1:0]  imm7  = DW'(instr_word[7:1]);
  wire [DW-1:0]  imm16 = DW'(param_word);
  wire [IW-5:0]  grp   = instr_word[IW-1:4];

  assign instr_ready = !bus_valid;
  assign acc0 = acc_q[0];
  assign acc1 = acc_q[1];

  function automatic logic [1:0] flags_of(input logic [DW-1:0] r);
    return {r == '0, r[DW-1] | (r == '0)};
  endfunction

  always_comb begin
    kind = K_BAD;
    res  = '0;
    if (instr_word[15:12] == 4'b1010) begin
      kind = K_ALU;
      case (instr_word[11:8])
        4'b0000: res = opa + imm7;
        4'b0001: res = opa - imm7;
        4'b0010: res = imm7;
        4'b1000: res = opa & imm7;
        4'b1110: res = opa << instr_word[7:1];
        4'b1111: res = opa >> instr_word[7:1];
        default: kind = K_BAD;
      endcase
    end else if (grp == 12'hE00) begin
      kind = K_ALU;
      case (instr_word[3:1])
        3'b001:  res = opa - imm16;
        3'b010:  res = imm16;
        3'b100:  res = opa & imm16;
        3'b101:  res = opa | imm16;
        default: kind = K_BAD;
      endcase
    end else if (grp == 12'hE04 && instr_word[3:2] == 2'b00) begin
      kind = K_ALU;
      res  = opa + opb;
    end else if (grp == 12'hE05 && instr_word[3] == 1'b0) begin
      kind = K_ALU;
      res  = instr_word[2] ? (opa | opb) : (opa & opb);
    end else if (grp == 12'hE0C && instr_word[3:2] == 2'b00) begin
      kind = instr_word[1] ? K_STORE : K_LOAD;
    end else if (instr_word == 16'hE190) begin
      kind = K_NOP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q[0]  <= '0;
      acc_q[1]  <= '0;
      flag_z    <= 1'b1;
      flag_le   <= 1'b1;
      done      <= 1'b0;
      illegal   <= 1'b0;
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      ld_sel    <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (bus_valid) begin
        if (bus_ready) begin
          bus_valid <= 1'b0;
          done      <= 1'b1;
          if (!bus_write) begin
            acc_q[ld_sel]     <= bus_rdata;
            {flag_z, flag_le} <= flags_of(bus_rdata);
          end
        end
      end else if (instr_valid) begin
        case (kind)
          K_ALU: begin
            acc_q[sel_a]      <= res;
            {flag_z, flag_le} <= flags_of(res);
            done              <= 1'b1;
          end
          K_NOP: done <= 1'b1;
          K_LOAD, K_STORE: begin
            bus_valid <= 1'b1;
            bus_write <= (kind == K_STORE);
            bus_addr  <= param_word;
            bus_wdata <= opa;
            ld_sel    <= sel_a;
          end
          default: illegal <= 1'b1;
        endcase
      end
    end
  end

endmodule

module dual_acc_exec_chk #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic          instr_ready,
  input logic [IW-1:0] instr_word,
  input logic          done,
  input logic          illegal,
  input logic [DW-1:0] acc0,
  input logic [DW-1:0] acc1,
  input logic          flag_z,
  input logic          flag_le,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [IW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready
);

  a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write));

  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !instr_ready);

  a_r7_done_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready |=> done && !bus_valid);

  a_r8_store_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write |=> $stable(acc0) && $stable(acc1) && $stable(flag_z) && $stable(flag_le));

  a_r10_nop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_ready && instr_word == 16'hE190 |=>
      done && $stable(acc0) && $stable(acc1) && $stable(flag_z) && $stable(flag_le));

  a_r11_illegal_clean: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !done && $stable(acc0) && $stable(acc1) && $stable(flag_z) && $stable(flag_le));

  a_r6_z_implies_le: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> flag_le);

endmodule

bind dual_acc_exec dual_acc_exec_chk #(.DW(DW), .IW(IW)) u_chk (.*);

// File: tb/dual_acc_exec_bench.sv
`timescale 1ns/1ps
module dual_acc_exec_bench;
  localparam int K_ALU = 0, K_NOP = 1, K_LOAD = 2, K_STORE = 3, K_BAD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr_word = '0, param_word = '0;
  logic        done, illegal;
  logic [31:0] acc0, acc1;
  logic        flag_z, flag_le;
  logic        bus_valid, bus_write;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_rdata = '0;

  int checks = 0, errors = 0;
  logic [31:0] m0 = '0, m1 = '0;
  logic        mz = 1'b1, mle = 1'b1;

  always #2.5 clk = ~clk;

  dual_acc_exec u_dual_acc_exec (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [15:0] w);
    if (w[15:12] == 4'hA) return (w[11:8] inside {4'h0, 4'h1, 4'h2, 4'h8, 4'hE, 4'hF}) ? K_ALU : K_BAD;
    if (w[15:4] == 12'hE00) return (w[3:1] inside {3'd1, 3'd2, 3'd4, 3'd5}) ? K_ALU : K_BAD;
    if (w[15:4] == 12'hE04) return (w[3:2] == 2'b00) ? K_ALU : K_BAD;
    if (w[15:4] == 12'hE05) return (w[3] == 1'b0) ? K_ALU : K_BAD;
    if (w[15:4] == 12'hE0C && w[3:2] == 2'b00) return w[1] ? K_STORE : K_LOAD;
    if (w == 16'hE190) return K_NOP;
    return K_BAD;
  endfunction

  function automatic string tag_of(input logic [15:0] w, input int k);
    if (k == K_BAD) return "R11";
    if (k == K_NOP) return "R10";
    if (k == K_LOAD) return "R7";
    if (k == K_STORE) return "R8";
    if (w[15:12] == 4'hA) return (w[11:8] < 4'h3) ? "R2" : "R3";
    if (w[15:4] == 12'hE00) return "R4";
    return "R5";
  endfunction

  function automatic logic [31:0] expect_res(input logic [15:0] w, input logic [15:0] p, input logic [31:0] a, input logic [31:0] b);
    int unsigned n = w[7:1];
    logic [31:0] i7 = {25'd0, w[7:1]};
    logic [31:0] i16 = {16'd0, p};
    if (w[15:12] == 4'hA) begin
      case (w[11:8])
        4'h0: return a + i7;
        4'h1: return a - i7;
        4'h2: return i7;
        4'h8: return a & i7;
        4'hE: return (n >= 32) ? 32'd0 : a * (32'd1 << n);
        default: return (n >= 32) ? 32'd0 : a / (32'd1 << n);
      endcase
    end
    if (w[15:4] == 12'hE00) begin
      case (w[3:1])
        3'd1: return a - i16;
        3'd2: return i16;
        3'd4: return a & i16;
        default: return a | i16;
      endcase
    end
    if (w[15:4] == 12'hE04) return a + b;
    return w[2] ? (a | b) : (a & b);
  endfunction

  task automatic set_model(input logic sel, input logic [31:0] r);
    if (sel) m1 = r; else m0 = r;
    mz  = (r == 0);
    mle = ($signed(r) <= 0);
  endtask

  task automatic exec(input logic [15:0] w, input logic [15:0] p, input int stall);
    int k = kind_of(w);
    string t = tag_of(w, k);
    logic [31:0] a = w[0] ? m1 : m0;
    logic [31:0] b = w[1] ? m1 : m0;
    logic [31:0] rd = {w, p} ^ 32'hC3A5_0F1E;
    @(negedge clk);
    instr_word = w; param_word = p; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    if (k == K_LOAD || k == K_STORE) begin
      chk(t, "bus_valid", 32'(bus_valid), 32'd1);
      chk(t, "bus_write", 32'(bus_write), 32'(k == K_STORE));
      chk(t, "bus_addr", 32'(bus_addr), 32'(p));
      if (k == K_STORE) chk(t, "bus_wdata", bus_wdata, a);
      for (int i = 0; i < stall; i++) begin
        instr_valid = 1'b1; instr_word = 16'hA2FF; param_word = ~p;
        @(negedge clk);
        chk("R9", "held valid", 32'(bus_valid), 32'd1);
        chk("R9", "held addr", 32'(bus_addr), 32'(p));
        chk("R9", "ready low", 32'(instr_ready), 32'd0);
        chk("R9", "no done", 32'(done), 32'd0);
      end
      instr_valid = 1'b0;
      bus_rdata = rd; bus_ready = 1'b1;
      @(negedge clk);
      bus_ready = 1'b0;
      if (k == K_LOAD) set_model(w[0], rd);
      chk(t, "bus released", 32'(bus_valid), 32'd0);
    end else if (k == K_ALU) begin
      set_model(w[0], expect_res(w, p, a, b));
    end
    chk(t, "done", 32'(done), 32'(k != K_BAD));
    chk(t, "illegal", 32'(illegal), 32'(k == K_BAD));
    chk(t, "acc0", acc0, m0);
    chk(t, "acc1", acc1, m1);
    chk(t, "flags", {30'd0, flag_z, flag_le}, {30'd0, mz, mle});
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "acc0", acc0, 32'd0);
    chk("R1", "acc1", acc1, 32'd0);
    chk("R1", "flags", {30'd0, flag_z, flag_le}, 32'd3);
    chk("R1", "pulses", {29'd0, done, illegal, bus_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    exec(16'hA203, 16'h0, 0);
    exec(16'hAE3F, 16'h0, 0);
    chk("R6", "negative le", {30'd0, flag_z, flag_le}, 32'd1);
    chk("R3", "shift 31", acc1, 32'h8000_0000);
    exec(16'hAE41, 16'h0, 0);
    chk("R3", "shift 32 zero", acc1, 32'd0);
    chk("R6", "zero flags", {30'd0, flag_z, flag_le}, 32'd3);
    exec(16'hE004, 16'h7FFF, 0);
    chk("R12", "visible at done", acc0, 32'h0000_7FFF);
    exec(16'hE043, 16'h0, 0);
    exec(16'hE040, 16'h0, 0);
    chk("R5", "A+=A", acc0, 32'h0000_FFFE);
    exec(16'hE0C2, 16'h1234, 3);
    exec(16'hE0C1, 16'hBEEF, 5);
    exec(16'hE190, 16'h0, 0);
    exec(16'hE001, 16'h1, 0);

    for (int i = 0; i < 65536; i++) begin
      logic [31:0] v = i * 32'd40503;
      exec(i[15:0], v[15:0] ^ 16'h5A5A, (i[15:4] == 12'hE0C) ? 1 : 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule